// File: doc/BRIEF.md
# SPI Serial Flash Command Slave

This block is the target side of a serial flash link. An external host selects it with an active-low chip select and exchanges bits on a serial clock in either idle-low (mode 0) or idle-high (mode 3) polarity. The block samples the serial pins on its own system clock, finds the clock edges, and runs a command state machine. The state machine takes an 8-bit opcode, then an address, dummy or data field as the opcode requires, and then either streams bytes back or collects bytes to write. Every field is sent most significant bit first.

Modifying commands are page program, page erase, sector erase, bulk erase and status write. They act on a small behavioural array model only when chip select rises exactly at the end of a complete command. The model holds a parameterised number of 256-byte pages, with all ones as its erased state. Each modifying command starts a busy window whose length in system clocks comes from the `busy_len` input. A separate policy block may veto all modifications through `wr_inhibit`. A software-protect (sleep) mode shuts out every command except the wake command, which also returns a fixed signature byte.

States of the command engine: `S_IDLE` (deselected), `S_OPC` (opcode bits), `S_ADDR` (24 address or wake-dummy bits), `S_DUMMY` (fast-read dummy byte), `S_DOUT` (array data out), `S_STAT` (status byte out), `S_SIG` (signature out), `S_WDATA` (program data in), `S_SRIN` (status byte in), `S_DONE` (command complete, waiting for deselect) and `S_IGNORE` (input discarded until deselect). Transitions: select takes `S_IDLE` to `S_OPC`. The 8th opcode bit goes to `S_DONE`, `S_STAT`, `S_SRIN`, `S_ADDR` or `S_IGNORE` according to the opcode, the sleep flag and the busy flag. The 24th address bit goes to `S_DOUT` (read), `S_DUMMY` (fast read), `S_WDATA` (program), `S_DONE` (page or sector erase) or `S_SIG` (wake). The 8th dummy bit goes to `S_DOUT`. The 8th status bit goes to `S_DONE`. Any clock edge in `S_DONE` goes to `S_IGNORE`. Deselect takes every state back to `S_IDLE`.

Top module: `spi_flash_slave`

## Requirements
- R1: Opcodes are write-enable 06h, write-disable 04h, status read 05h, status write 01h, read 03h, fast read 0Bh, page program 02h, page erase 81h, sector erase D8h, bulk erase C7h, sleep B9h and wake ABh. All fields are sent MSB first. Input is sampled on rising serial-clock edges and output changes after falling edges, in both mode 0 and mode 3.
- R2: `miso_oe` is 0 after reset, while deselected, and in every state other than status, data or signature output.
- R3: Read takes a 3-byte address and fast read takes a 3-byte address and one dummy byte. Address bits above the model's array width are ignored. Output bytes follow from consecutive addresses, wrapping from the top array address to 0.
- R4: Page program writes each data byte to the column given by the low 8 address bits and then increments only those bits, so the column wraps inside the page and later bytes overwrite earlier ones. On commit each stored byte becomes the AND of its old value and the new one, and columns that were not sent are left unchanged.
- R5: Page erase sets the addressed page to FFh. Sector erase sets every page of the addressed group of `SECT_PAGES` pages to FFh. Bulk erase sets the whole array to FFh.
- R6: Write-enable, write-disable, sleep, status write, erase and program take effect only if chip select rises right after the last bit of the command. For program this means a whole number of data bytes, at least one. Any extra or missing bit cancels the command.
- R7: The write-enable latch is set by write-enable and cleared by write-disable. Program, erase and status write need the latch set and `wr_inhibit` low, and clear the latch when they start. A refused command leaves the array, the status and the latch unchanged.
- R8: A started program, erase or status write holds status bit 0 at 1 for `busy_len` system clocks. While busy, every opcode except status read is discarded.
- R9: An unknown opcode keeps `miso_oe` low for the rest of the selection, and the next selection works normally.
- R10: In sleep mode every opcode except wake is discarded. Wake followed by 3 dummy bytes streams the signature 11h repeatedly, and raising chip select after a wake opcode leaves sleep mode.
- R11: The status byte reads {bit7 cfg, 000, bit3 cfg, bit2 cfg, write-enable latch, busy}. Status write stores data bits 7, 3 and 2, which also drive `cfg_bits` as {bit7, bit3, bit2}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso`; 0 means high impedance |
| wr_inhibit | input | 1 | Policy veto on every modification |
| busy_len | input | BUSY_W | Busy window length in system clocks |
| cfg_bits | output | 3 | Stored status bits 7, 3 and 2 |

## Verification
Status reads before and after write-enable, and in each clock polarity, show whether the edge sampling and the output timing work in both modes. Program tests send two bytes into an erased page, then a second pass over used data to check the AND rule, then three bytes that start two columns below the page end, which separates column wrapping from a full-address increment. Reads that straddle the top address, that carry junk in the upper address bits, and that insert a dummy byte tell the three address paths apart. Each modifying command and sleep is sent once with a trailing extra bit and once exact, and is also sent while busy, while inhibited or while asleep, so that a refused command can be told apart from an executed one.

// File: rtl/sfl_pkg.sv
package sfl_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_DOUT, S_STAT,
        S_SIG, S_WDATA, S_SRIN, S_DONE, S_IGNORE
    } sfl_state_e;

    typedef enum logic [2:0] {
        J_NONE, J_PROG, J_PERASE, J_SERASE, J_BERASE, J_STAT
    } sfl_job_e;

    localparam logic [7:0] C_WREN = 8'h06;
    localparam logic [7:0] C_WRDI = 8'h04;
    localparam logic [7:0] C_RDSR = 8'h05;
    localparam logic [7:0] C_WRSR = 8'h01;
    localparam logic [7:0] C_READ = 8'h03;
    localparam logic [7:0] C_FAST = 8'h0B;
    localparam logic [7:0] C_PP   = 8'h02;
    localparam logic [7:0] C_PE   = 8'h81;
    localparam logic [7:0] C_SE   = 8'hD8;
    localparam logic [7:0] C_BE   = 8'hC7;
    localparam logic [7:0] C_SP   = 8'hB9;
    localparam logic [7:0] C_RES  = 8'hAB;
    localparam logic [7:0] SIG_BYTE = 8'h11;
endpackage

// File: rtl/sfl_pin_sync.sv
module sfl_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise,
    output logic cs_hi,
    output logic mosi_s
);
    logic [STAGES:0]   sck_p;
    logic [STAGES:0]   cs_p;
    logic [STAGES-1:0] mosi_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p  <= '0;
            cs_p   <= '1;
            mosi_p <= '0;
        end else begin
            sck_p  <= {sck_p[STAGES-1:0], sck};
            cs_p   <= {cs_p[STAGES-1:0], cs_n};
            mosi_p <= {mosi_p[STAGES-2:0], mosi};
        end
    end

    assign sck_rise = sck_p[STAGES-1] & ~sck_p[STAGES];
    assign sck_fall = ~sck_p[STAGES-1] & sck_p[STAGES];
    assign cs_rise  = cs_p[STAGES-1] & ~cs_p[STAGES];
    assign cs_hi    = cs_p[STAGES-1];
    assign mosi_s   = mosi_p[STAGES-1];
endmodule

// File: rtl/sfl_array.sv
module sfl_array
    import sfl_pkg::*;
#(
    parameter int PAGES      = 4,
    parameter int SECT_PAGES = 2,
    parameter int BUSY_W     = 16,
    localparam int PW        = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int AW        = PW + 8,
    localparam int DEPTH     = PAGES * 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     rd_addr,
    output logic [7:0]        rd_data,
    input  logic              pb_clear,
    input  logic              pb_we,
    input  logic [7:0]        pb_col,
    input  logic [7:0]        pb_data,
    input  sfl_job_e          job,
    input  logic              job_go,
    input  logic [PW-1:0]     job_page,
    input  logic [BUSY_W-1:0] busy_len,
    output logic              busy
);
    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [256];
    logic [BUSY_W-1:0] busy_cnt;
    logic [PAGES-1:0]  page_hit;

    always_comb begin
        for (int p = 0; p < PAGES; p++) begin
            case (job)
                J_PROG, J_PERASE: page_hit[p] = (PW'(p) == job_page);
                J_SERASE:         page_hit[p] = ((p / SECT_PAGES) == (int'(job_page) / SECT_PAGES));
                J_BERASE:         page_hit[p] = 1'b1;
                default:          page_hit[p] = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            for (int i = 0; i < 256; i++) pbuf[i] <= 8'hFF;
            busy_cnt <= '0;
        end else begin
            if (pb_clear) begin
                for (int i = 0; i < 256; i++) pbuf[i] <= 8'hFF;
            end else if (pb_we) begin
                pbuf[pb_col] <= pb_data;
            end
            if (job_go) begin
                busy_cnt <= busy_len;
                for (int p = 0; p < PAGES; p++) begin
                    for (int i = 0; i < 256; i++) begin
                        if (page_hit[p]) begin
                            mem[AW'(p * 256 + i)] <= (job == J_PROG)
                                ? (mem[AW'(p * 256 + i)] & pbuf[8'(i)]) : 8'hFF;
                        end
                    end
                end
            end else if (busy_cnt != '0) begin
                busy_cnt <= busy_cnt - 1'b1;
            end
        end
    end

    assign rd_data = mem[rd_addr];
    assign busy    = (busy_cnt != '0);

    // R8
    busy_no_job_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !job_go);

    // R8
    busy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_go |=> (busy == ($past(busy_len) != '0)));
endmodule

// File: rtl/sfl_cmd_fsm.sv
module sfl_cmd_fsm
    import sfl_pkg::*;
#(
    parameter int AW = 10,
    localparam int PW = AW - 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_rise,
    input  logic          sck_fall,
    input  logic          cs_rise,
    input  logic          cs_hi,
    input  logic          mosi_s,
    input  logic          busy,
    input  logic          wr_inhibit,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          pb_clear,
    output logic          pb_we,
    output logic [7:0]    pb_col,
    output logic [7:0]    pb_data,
    output sfl_job_e      job,
    output logic          job_go,
    output logic [PW-1:0] job_page,
    output logic          miso,
    output logic          miso_oe,
    output logic [2:0]    cfg_bits
);
    sfl_state_e state, state_nx, op_target, addr_target;
    logic [4:0]  bcnt;
    logic [7:0]  sh, opc, cur_byte;
    logic [23:0] addr;
    logic        wel, sleep, res_seen, pp_any, miso_r, may_write, out_state;
    logic [2:0]  cfg;
    logic [7:0]  in_byte;

    assign in_byte   = {sh[6:0], mosi_s};
    assign may_write = wel && !wr_inhibit;
    assign out_state = (state == S_STAT) || (state == S_DOUT) || (state == S_SIG);

    always_comb begin
        op_target = S_IGNORE;
        if (sleep) begin
            if (in_byte == C_RES) op_target = S_ADDR;
        end else if (busy) begin
            if (in_byte == C_RDSR) op_target = S_STAT;
        end else begin
            case (in_byte)
                C_WREN, C_WRDI, C_BE, C_SP:                 op_target = S_DONE;
                C_RDSR:                                     op_target = S_STAT;
                C_WRSR:                                     op_target = S_SRIN;
                C_READ, C_FAST, C_PP, C_PE, C_SE, C_RES:    op_target = S_ADDR;
                default:                                    op_target = S_IGNORE;
            endcase
        end
    end

    always_comb begin
        case (opc)
            C_READ:      addr_target = S_DOUT;
            C_FAST:      addr_target = S_DUMMY;
            C_PP:        addr_target = S_WDATA;
            C_PE, C_SE:  addr_target = S_DONE;
            C_RES:       addr_target = S_SIG;
            default:     addr_target = S_IGNORE;
        endcase
    end

    always_comb begin
        state_nx = state;
        if (cs_hi) begin
            state_nx = S_IDLE;
        end else if (state == S_IDLE) begin
            state_nx = S_OPC;
        end else if (sck_rise) begin
            unique case (state)
                S_OPC:   if (bcnt == 5'd7)  state_nx = op_target;
                S_ADDR:  if (bcnt == 5'd23) state_nx = addr_target;
                S_DUMMY: if (bcnt == 5'd7)  state_nx = S_DOUT;
                S_SRIN:  if (bcnt == 5'd7)  state_nx = S_DONE;
                S_DONE:  state_nx = S_IGNORE;
                default: state_nx = state;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // datapath, counters and commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt <= '0; sh <= '0; opc <= '0; addr <= '0;
            wel <= 1'b0; sleep <= 1'b0; res_seen <= 1'b0; pp_any <= 1'b0;
            cfg <= '0; pb_clear <= 1'b0; pb_we <= 1'b0; pb_col <= '0;
            pb_data <= '0; job <= J_NONE; job_go <= 1'b0;
        end else begin
            pb_clear <= 1'b0;
            pb_we    <= 1'b0;
            job_go   <= 1'b0;
            if (cs_hi) begin
                bcnt <= '0;
                if (cs_rise) begin
                    if (res_seen) begin
                        sleep    <= 1'b0;
                        res_seen <= 1'b0;
                    end
                    if (state == S_DONE) begin
                        case (opc)
                            C_WREN: wel   <= 1'b1;
                            C_WRDI: wel   <= 1'b0;
                            C_SP:   sleep <= 1'b1;
                            C_PE, C_SE, C_BE: if (may_write) begin
                                job    <= (opc == C_PE) ? J_PERASE :
                                          (opc == C_SE) ? J_SERASE : J_BERASE;
                                job_go <= 1'b1;
                                wel    <= 1'b0;
                            end
                            C_WRSR: if (may_write) begin
                                cfg    <= {sh[7], sh[3], sh[2]};
                                job    <= J_STAT;
                                job_go <= 1'b1;
                                wel    <= 1'b0;
                            end
                            default: ;
                        endcase
                    end else if (state == S_WDATA && bcnt == 5'd0 && pp_any && may_write) begin
                        job    <= J_PROG;
                        job_go <= 1'b1;
                        wel    <= 1'b0;
                    end
                end
            end else if (sck_rise) begin
                sh <= in_byte;
                if (state_nx != state)
                    bcnt <= '0;
                else if ((out_state || state == S_WDATA) && bcnt[2:0] == 3'd7)
                    bcnt <= '0;
                else
                    bcnt <= bcnt + 1'b1;
                if (state == S_OPC && bcnt == 5'd7) begin
                    opc <= in_byte;
                    if (sleep && in_byte == C_RES) res_seen <= 1'b1;
                end
                if (state == S_ADDR) begin
                    addr <= {addr[22:0], mosi_s};
                    if (bcnt == 5'd23 && opc == C_PP) begin
                        pb_clear <= 1'b1;
                        pp_any   <= 1'b0;
                    end
                end
                if (state == S_DOUT && bcnt == 5'd7)
                    addr[AW-1:0] <= addr[AW-1:0] + 1'b1;
                if (state == S_WDATA && bcnt == 5'd7) begin
                    pb_we     <= 1'b1;
                    pb_col    <= addr[7:0];
                    pb_data   <= in_byte;
                    addr[7:0] <= addr[7:0] + 1'b1;
                    pp_any    <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        case (state)
            S_STAT:  cur_byte = {cfg[2], 3'b000, cfg[1:0], wel, busy};
            S_SIG:   cur_byte = SIG_BYTE;
            default: cur_byte = rd_data;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     miso_r <= 1'b0;
        else if (sck_fall && out_state) miso_r <= cur_byte[~bcnt[2:0]];
    end

    assign miso     = miso_r;
    assign miso_oe  = out_state;
    assign rd_addr  = addr[AW-1:0];
    assign job_page = addr[AW-1:8];
    assign cfg_bits = cfg;

    // R2
    oe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !miso_oe);

    // R7
    wel_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        job_go |-> (!wel && $past(wel)));

    // R4
    page_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WDATA && $past(state == S_WDATA)) |-> $stable(addr[23:8]));

    // R10
    sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!(state inside {S_STAT, S_DOUT, S_DONE}) && !job_go));
endmodule

// File: rtl/spi_flash_slave.sv
module spi_flash_slave
    import sfl_pkg::*;
#(
    parameter int PAGES       = 4,
    parameter int SECT_PAGES  = 2,
    parameter int SYNC_STAGES = 2,
    parameter int BUSY_W      = 16,
    localparam int PW         = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int AW         = PW + 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    input  logic              wr_inhibit,
    input  logic [BUSY_W-1:0] busy_len,
    output logic [2:0]        cfg_bits
);
    logic          sck_rise, sck_fall, cs_rise, cs_hi, mosi_s, busy;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data, pb_col, pb_data;
    logic          pb_clear, pb_we, job_go;
    logic [PW-1:0] job_page;
    sfl_job_e      job;

    sfl_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_rise(cs_rise),
        .cs_hi(cs_hi), .mosi_s(mosi_s)
    );

    sfl_cmd_fsm #(.AW(AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sck_rise(sck_rise), .sck_fall(sck_fall),
        .cs_rise(cs_rise), .cs_hi(cs_hi), .mosi_s(mosi_s), .busy(busy),
        .wr_inhibit(wr_inhibit), .rd_data(rd_data), .rd_addr(rd_addr),
        .pb_clear(pb_clear), .pb_we(pb_we), .pb_col(pb_col), .pb_data(pb_data),
        .job(job), .job_go(job_go), .job_page(job_page),
        .miso(miso), .miso_oe(miso_oe), .cfg_bits(cfg_bits)
    );

    sfl_array #(.PAGES(PAGES), .SECT_PAGES(SECT_PAGES), .BUSY_W(BUSY_W)) u_array (
        .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
        .pb_clear(pb_clear), .pb_we(pb_we), .pb_col(pb_col), .pb_data(pb_data),
        .job(job), .job_go(job_go), .job_page(job_page),
        .busy_len(busy_len), .busy(busy)
    );
endmodule

// File: tb/spi_flash_slave_test.sv
module spi_flash_slave_test;
    localparam int CLK_P = 10;
    localparam int HALF  = 6;

    logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic wr_inhibit = 1'b0;
    logic [15:0] busy_len = 16'd600;
    logic miso, miso_oe;
    logic [2:0] cfg_bits;

    logic [7:0] tx [16];
    logic [7:0] rx [16];
    bit oe_seen, cpol, finished;
    int n_checks = 0, n_bad = 0;

    spi_flash_slave uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .wr_inhibit(wr_inhibit),
        .busy_len(busy_len), .cfg_bits(cfg_bits)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic xfer(input int nb, input int extra);
        oe_seen = 1'b0;
        sck = cpol;
        cs_n = 1'b0;
        tick(4);
        for (int b = 0; b < nb; b++) begin
            for (int k = 7; k >= 0; k--) begin
                sck = 1'b0; mosi = tx[b][k]; tick(HALF);
                rx[b][k] = miso;
                if (miso_oe) oe_seen = 1'b1;
                sck = 1'b1; tick(HALF);
            end
        end
        for (int e = 0; e < extra; e++) begin
            sck = 1'b0; mosi = 1'b1; tick(HALF);
            sck = 1'b1; tick(HALF);
        end
        if (!cpol) sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic cmd(input logic [7:0] op, input int extra);
        tx[0] = op;
        xfer(1, extra);
    endtask

    task automatic rdsr();
        tx[0] = 8'h05; tx[1] = 8'h00;
        xfer(2, 0);
    endtask

    task automatic wait_ready();
        for (int i = 0; i < 40; i++) begin
            rdsr();
            if (rx[1][0] == 1'b0) break;
        end
    endtask

    task automatic send_addr_cmd(input logic [7:0] op, input logic [23:0] a, input int nb, input int extra);
        tx[0] = op; tx[1] = a[23:16]; tx[2] = a[15:8]; tx[3] = a[7:0];
        xfer(nb, extra);
    endtask

    task automatic read_at(input logic [23:0] a, input int n);
        for (int i = 4; i < 16; i++) tx[i] = 8'h00;
        send_addr_cmd(8'h03, a, 4 + n, 0);
    endtask

    task automatic prog(input logic [23:0] a, input int n, input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
        cmd(8'h06, 0);
        tx[4] = d0; tx[5] = d1; tx[6] = d2;
        send_addr_cmd(8'h02, a, 4 + n, 0);
    endtask

    task automatic erase(input logic [7:0] op, input logic [23:0] a, input int extra);
        cmd(8'h06, 0);
        if (op == 8'hC7) cmd(op, extra);
        else send_addr_cmd(op, a, 4, extra);
        wait_ready();
    endtask

    task automatic t_reset();
        chk("R2 oe after reset", {7'd0, miso_oe}, 8'h00);
        chk("R11 cfg after reset", {5'd0, cfg_bits}, 8'h00);
        rdsr();
        chk("R11 status after reset", rx[1], 8'h00);
    endtask

    task automatic t_wel();
        cmd(8'h06, 0); rdsr();
        chk("R7 R1 write enable mode 0", rx[1], 8'h02);
        cpol = 1'b1;
        cmd(8'h04, 0); rdsr();
        chk("R7 R1 write disable mode 3", rx[1], 8'h00);
        cpol = 1'b0;
        cmd(8'h06, 1); rdsr();
        chk("R6 write enable with extra bit", rx[1], 8'h00);
    endtask

    task automatic t_program();
        prog(24'h000010, 2, 8'hA5, 8'h3C, 8'h00);
        rdsr();
        chk("R8 busy after program", {7'd0, rx[1][0]}, 8'h01);
        cmd(8'h06, 0);
        wait_ready();
        chk("R8 R7 enable ignored while busy", rx[1], 8'h00);
        read_at(24'h000010, 3);
        chk("R4 program byte 0", rx[4], 8'hA5);
        chk("R4 program byte 1", rx[5], 8'h3C);
        chk("R4 unsent column kept", rx[6], 8'hFF);
        prog(24'h000010, 1, 8'h0F, 8'h00, 8'h00); wait_ready();
        read_at(24'h000010, 1);
        chk("R4 program ANDs", rx[4], 8'h05);
        prog(24'h0001FE, 3, 8'h11, 8'h22, 8'h33); wait_ready();
        read_at(24'h0001FE, 2);
        chk("R4 column FE", rx[4], 8'h11);
        chk("R4 column FF", rx[5], 8'h22);
        read_at(24'h000100, 1);
        chk("R4 column wraps in page", rx[4], 8'h33);
        read_at(24'h000200, 1);
        chk("R4 next page untouched", rx[4], 8'hFF);
    endtask

    task automatic t_read();
        prog(24'h0003FF, 1, 8'hC3, 8'h00, 8'h00); wait_ready();
        prog(24'h000000, 1, 8'h5A, 8'h00, 8'h00); wait_ready();
        read_at(24'h0003FF, 2);
        chk("R3 read top", rx[4], 8'hC3);
        chk("R3 read wraps to zero", rx[5], 8'h5A);
        read_at(24'hFC03FF, 1);
        chk("R3 upper address ignored", rx[4], 8'hC3);
        cpol = 1'b1;
        for (int i = 4; i < 16; i++) tx[i] = 8'h00;
        send_addr_cmd(8'h0B, 24'h000010, 7, 0);
        chk("R3 R1 fast read mode 3 byte 0", rx[5], 8'h05);
        chk("R3 R1 fast read mode 3 byte 1", rx[6], 8'h3C);
        cpol = 1'b0;
    endtask

    task automatic t_erase();
        erase(8'h81, 24'h000010, 1);
        read_at(24'h000010, 1);
        chk("R6 page erase with extra bit", rx[4], 8'h05);
        cmd(8'h04, 0);
        erase(8'h81, 24'h000010, 0);
        read_at(24'h000010, 1);
        chk("R5 page erase", rx[4], 8'hFF);
        read_at(24'h000100, 1);
        chk("R5 page erase leaves page 1", rx[4], 8'h33);
        erase(8'hD8, 24'h000000, 0);
        read_at(24'h000100, 1);
        chk("R5 sector erase page 1", rx[4], 8'hFF);
        read_at(24'h0003FF, 1);
        chk("R5 sector erase leaves page 3", rx[4], 8'hC3);
        erase(8'hC7, 24'h0, 0);
        read_at(24'h0003FF, 1);
        chk("R5 bulk erase", rx[4], 8'hFF);
    endtask

    task automatic t_inhibit();
        wr_inhibit = 1'b1;
        prog(24'h000020, 1, 8'h77, 8'h00, 8'h00); tick(20);
        wr_inhibit = 1'b0;
        read_at(24'h000020, 1);
        chk("R7 inhibit blocks program", rx[4], 8'hFF);
        rdsr();
        chk("R7 refused program keeps latch", rx[1], 8'h02);
    endtask

    task automatic t_wrsr();
        cmd(8'h06, 0);
        tx[0] = 8'h01; tx[1] = 8'hFF; xfer(2, 0);
        wait_ready();
        chk("R11 status write fields", rx[1], 8'h8C);
        chk("R11 cfg bits", {5'd0, cfg_bits}, 8'h07);
        cmd(8'h06, 0);
        tx[0] = 8'h01; tx[1] = 8'h00; xfer(2, 1);
        rdsr();
        chk("R6 status write with extra bit", rx[1], 8'h8E);
        tx[0] = 8'h01; tx[1] = 8'h00; xfer(2, 0);
        wait_ready();
        chk("R11 status write clears", rx[1], 8'h00);
    endtask

    task automatic t_invalid();
        tx[0] = 8'h55; tx[1] = 8'h00; tx[2] = 8'h00; tx[3] = 8'h00;
        xfer(4, 0);
        chk("R9 unknown opcode output off", {7'd0, oe_seen}, 8'h00);
        rdsr();
        chk("R9 next selection works", {7'd0, oe_seen}, 8'h01);
    endtask

    task automatic t_sleep();
        cmd(8'hB9, 1);
        rdsr();
        chk("R6 R10 sleep with extra bit not entered", {7'd0, oe_seen}, 8'h01);
        cmd(8'hB9, 0);
        rdsr();
        chk("R10 status read ignored in sleep", {7'd0, oe_seen}, 8'h00);
        cmd(8'h06, 0);
        for (int i = 1; i < 6; i++) tx[i] = 8'h00;
        tx[0] = 8'hAB;
        xfer(6, 0);
        chk("R10 signature first", rx[4], 8'h11);
        chk("R10 signature repeats", rx[5], 8'h11);
        rdsr();
        chk("R10 awake after wake", {7'd0, oe_seen}, 8'h01);
        chk("R10 enable ignored in sleep", rx[1], 8'h00);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        cpol = 1'b0;
        t_reset();
        t_wel();
        t_program();
        t_read();
        t_erase();
        t_inhibit();
        t_wrsr();
        t_invalid();
        t_sleep();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule